// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the host-facing register and interrupt logic of a two-channel serial controller. A processor reaches it over a byte-wide memory-mapped bus. Each channel has two byte ports: a command port and a data port. Sixteen write registers and sixteen read registers per channel sit behind the command port. The processor reaches them indirectly. It first writes a register index, and the next command access reads or writes that register. Any command read, or the second command write, returns the index to zero.

A data-port write hands a byte to the transmit side on a valid/data output. A data-port read pops the oldest byte from that channel's receive ring. Receive bytes enter from the line side on a valid/data input, or come from the block's own transmit path when local loopback is on. One shared pending register and one interrupt output serve both channels. The interrupt controls are all held in channel A. Reading the pending register, or reading either data port, acknowledges the interrupt.

Top module: `dsr_top`

## Requirements
- R1: After synchronous reset, tx_valid, irq, rx_overrun and bus_rdata are 0, both receive rings are empty, and a command read on either channel returns status 0x04.
- R2: Address bit 3 picks the channel. Offset 1 (bits 2:0) is the command port and offset 5 is the data port. A command write with no index pending latches the low 4 bits of the byte as the register index. The next command write stores the byte in that write register and returns the index to 0 with nothing pending.
- R3: A command read returns the read register at the current index, one cycle after the access on bus_rdata. It then returns the index to 0, so the next command read returns register 0.
- R4: Read registers 12 and 13 of a channel return the last values written to write registers 12 and 13 of that same channel.
- R5: Read register 0 has bit 2 (transmit empty) always set and bit 0 set exactly while that channel's receive ring is non-empty. All its other bits are 0. Read register 1 always reads 0.
- R6: A data-port write drives tx_valid high for one cycle, on the cycle after the access, with tx_data equal to the byte and tx_chan equal to the channel.
- R7: Each channel's receive ring returns bytes in arrival order on data-port reads, one cycle after the access. A read of an empty ring returns 0 and leaves the ring unchanged. A byte with rx_valid high enters the ring picked by rx_chan.
- R8: When bit 4 of a channel's write register 14 is set, each data-port write on that channel also enters that channel's receive ring.
- R9: With bit 3 of channel A write register 9 set (master enable), a data-port write on a channel whose write register 1 bit 1 is set raises a transmit pending bit. This is bit 4 for channel A and bit 1 for channel B of read register 3 on channel A.
- R10: With master enable set, a non-empty ring raises a receive pending bit while channel A write register 1 bits 4:3 are non-zero. This is bit 5 for A and bit 2 for B. The same non-empty ring raises an external pending bit while channel A write register 1 bit 7 is set. This is bit 3 for A and bit 0 for B.
- R11: irq is high while master enable is set and some pending bit has its own enable set. irq is low while master enable is clear.
- R12: A command read of channel A register 3, or any data-port read, clears all pending bits. irq then falls unless a condition sets a bit again.
- R13: A ring holds 1023 bytes. The push that would make its write position equal to its read position sets that channel's rx_overrun bit, which stays set until reset. The ring then reads as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Bit 3 channel, bits 2:0 port offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after a read access |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_chan | output | 1 | Channel of the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte strobe |
| rx_chan | input | 1 | Channel of the receive byte |
| rx_data | input | 8 | Receive byte |
| rx_overrun | output | 2 | Sticky overrun flag per channel, bit 0 = A |
| irq | output | 1 | Interrupt request |

## Verification
Read data and the transmit strobe both appear one clock after the access edge. Each bus task holds the strobe for one cycle and samples at the following falling edge, which is exactly when that registered result is due.

A received byte is counted in the ring status right after the edge that takes it. The receive or external pending bit follows one edge later, and irq one edge after that. A transmit pending bit is set on the data-write edge itself, with irq one edge later. Interrupt checks therefore wait two idle cycles after the stimulus before they sample irq. Pending-register values are read through the normal command path before any clearing access.

Overrun is checked at its exact boundary: 1023 pushes leave the flag clear with data available, and the next push sets the flag.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int NCH    = 2;
  localparam int NREG   = 16;
  localparam int IDX_W  = $clog2(NREG);
  localparam int DW     = 8;
  localparam int BUS_AW = 4;
  localparam int CH_BIT = 3;

  localparam logic [2:0] OFS_CMD = 3'd1;
  localparam logic [2:0] OFS_DAT = 3'd5;

  // read register indices
  localparam int RR_STATUS = 0;
  localparam int RR_ERR    = 1;
  localparam int RR_PEND   = 3;
  localparam int RR_MIR_LO = 12;
  localparam int RR_MIR_HI = 13;

  // write register indices
  localparam int WR_IEN    = 1;
  localparam int WR_MASTER = 9;
  localparam int WR_MIR_LO = 12;
  localparam int WR_MIR_HI = 13;
  localparam int WR_MISC   = 14;

  // bit positions
  localparam int B_TXIE   = 1;
  localparam int B_RXM_LO = 3;
  localparam int B_RXM_HI = 4;
  localparam int B_EXTEN  = 7;
  localparam int B_MIE    = 3;
  localparam int B_LOOP   = 4;
  localparam int B_AVAIL  = 0;
  localparam int B_TXEMPT = 2;

  // pending register layout
  localparam int PEND_W  = 6;
  localparam int P_EXT_B = 0;
  localparam int P_TX_B  = 1;
  localparam int P_RX_B  = 2;
  localparam int P_EXT_A = 3;
  localparam int P_TX_A  = 4;
  localparam int P_RX_A  = 5;
endpackage

// File: rtl/dsr_chan_regs.sv
module dsr_chan_regs
  import dsr_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int REG_N  = 16,
  localparam int SEL_W  = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              cmd_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel_idx,
  output logic              master_en,
  output logic              tx_ie,
  output logic              rx_mode_en,
  output logic              ext_en,
  output logic              loop_en,
  output logic [DATA_W-1:0] mir_lo,
  output logic [DATA_W-1:0] mir_hi
);
  logic [DATA_W-1:0] wreg_q [REG_N];
  logic              pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      sel_idx <= '0;
      for (int i = 0; i < REG_N; i++) wreg_q[i] <= '0;
    end else if (cmd_rd) begin
      pend_q  <= 1'b0;
      sel_idx <= '0;
    end else if (cmd_wr) begin
      if (!pend_q) begin
        pend_q  <= 1'b1;
        sel_idx <= wdata[SEL_W-1:0];
      end else begin
        wreg_q[sel_idx] <= wdata;
        pend_q          <= 1'b0;
        sel_idx         <= '0;
      end
    end
  end

  assign master_en  = wreg_q[WR_MASTER][B_MIE];
  assign tx_ie      = wreg_q[WR_IEN][B_TXIE];
  assign rx_mode_en = |wreg_q[WR_IEN][B_RXM_HI:B_RXM_LO];
  assign ext_en     = wreg_q[WR_IEN][B_EXTEN];
  assign loop_en    = wreg_q[WR_MISC][B_LOOP];
  assign mir_lo     = wreg_q[WR_MIR_LO];
  assign mir_hi     = wreg_q[WR_MIR_HI];

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    pend_q && !cmd_wr && !cmd_rd |=> pend_q && $stable(sel_idx)); // R2

  AST_RD_RESETS_PTR: assert property (@(posedge clk) disable iff (rst)
    cmd_rd |=> !pend_q && sel_idx == '0); // R3
endmodule

// File: rtl/dsr_rx_ring.sv
module dsr_rx_ring #(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 1024,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              not_empty,
  output logic              overrun
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp, wp_n, rp_n;
  logic [DATA_W-1:0] rd_q;
  logic              rd_zero;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign not_empty = (wp != rp);
  assign wp_n      = push ? step(wp) : wp;
  assign rp_n      = (pop && not_empty) ? step(rp) : rp;

  // storage kept free of reset so it maps onto a block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop) rd_q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      rd_zero <= 1'b1;
      overrun <= 1'b0;
    end else begin
      wp <= wp_n;
      rp <= rp_n;
      if (pop) rd_zero <= !not_empty;
      if (push && (wp_n == rp_n)) overrun <= 1'b1;
    end
  end

  assign pop_data = rd_zero ? '0 : rd_q;

  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    pop && !not_empty && !push |=> !not_empty && $stable(rp)); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R13
endmodule

// File: rtl/dsr_irq_ctl.sv
module dsr_irq_ctl
  import dsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              master_en,
  input  logic              rx_mode_en,
  input  logic              ext_en,
  input  logic [NCH-1:0]    tx_ie,
  input  logic [NCH-1:0]    avail,
  input  logic [NCH-1:0]    tx_fire,
  input  logic              clr,
  output logic [PEND_W-1:0] pend,
  output logic              irq
);
  logic [PEND_W-1:0] set_v;
  logic              want;

  always_comb begin
    set_v          = '0;
    set_v[P_TX_A]  = master_en && tx_fire[0] && tx_ie[0];
    set_v[P_TX_B]  = master_en && tx_fire[1] && tx_ie[1];
    set_v[P_RX_A]  = master_en && rx_mode_en && avail[0];
    set_v[P_RX_B]  = master_en && rx_mode_en && avail[1];
    set_v[P_EXT_A] = master_en && ext_en && avail[0];
    set_v[P_EXT_B] = master_en && ext_en && avail[1];
  end

  assign want = master_en &&
                ((pend[P_TX_A] && tx_ie[0]) || (pend[P_TX_B] && tx_ie[1]) ||
                 (rx_mode_en && (pend[P_RX_A] || pend[P_RX_B])) ||
                 (ext_en && (pend[P_EXT_A] || pend[P_EXT_B])));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= clr ? '0 : (pend | set_v);
      irq  <= want;
    end
  end

  AST_CLR_WIPES: assert property (@(posedge clk) disable iff (rst)
    clr |=> pend == '0); // R12

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> !irq); // R11
endmodule

// File: rtl/dsr_top.sv
module dsr_top
  import dsr_pkg::*;
#(
  parameter int RING_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tx_valid,
  output logic              tx_chan,
  output logic [DW-1:0]     tx_data,
  input  logic              rx_valid,
  input  logic              rx_chan,
  input  logic [DW-1:0]     rx_data,
  output logic [NCH-1:0]    rx_overrun,
  output logic              irq
);
  logic bus_ch, cmd_acc, dat_acc, bus_wr, bus_rd, dat_wr, dat_rd, clr;

  assign bus_ch  = bus_addr[CH_BIT];
  assign cmd_acc = bus_valid && (bus_addr[2:0] == OFS_CMD);
  assign dat_acc = bus_valid && (bus_addr[2:0] == OFS_DAT);
  assign bus_wr  = bus_valid && bus_we;
  assign bus_rd  = bus_valid && !bus_we;
  assign dat_wr  = dat_acc && bus_we;
  assign dat_rd  = dat_acc && !bus_we;

  logic             ch_cmd_wr [NCH];
  logic             ch_cmd_rd [NCH];
  logic [IDX_W-1:0] ch_sel    [NCH];
  logic             ch_master [NCH];
  logic             ch_rxmode [NCH];
  logic             ch_ext    [NCH];
  logic             ch_loop   [NCH];
  logic [DW-1:0]    ch_mlo    [NCH];
  logic [DW-1:0]    ch_mhi    [NCH];
  logic [DW-1:0]    ch_pop    [NCH];
  logic [NCH-1:0]   avail, tx_ie, tx_fire;
  logic [PEND_W-1:0] pend;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          lb_hit, ext_hit, push;
    logic [DW-1:0] push_d;

    assign ch_cmd_wr[c] = cmd_acc && bus_we && (bus_ch == 1'(c));
    assign ch_cmd_rd[c] = cmd_acc && !bus_we && (bus_ch == 1'(c));
    assign tx_fire[c]   = dat_wr && (bus_ch == 1'(c));
    assign lb_hit       = tx_fire[c] && ch_loop[c];
    assign ext_hit      = rx_valid && (rx_chan == 1'(c));
    assign push         = lb_hit || ext_hit;
    assign push_d       = lb_hit ? bus_wdata : rx_data;

    dsr_chan_regs #(.DATA_W(DW), .REG_N(NREG)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .cmd_wr     (ch_cmd_wr[c]),
      .cmd_rd     (ch_cmd_rd[c]),
      .wdata      (bus_wdata),
      .sel_idx    (ch_sel[c]),
      .master_en  (ch_master[c]),
      .tx_ie      (tx_ie[c]),
      .rx_mode_en (ch_rxmode[c]),
      .ext_en     (ch_ext[c]),
      .loop_en    (ch_loop[c]),
      .mir_lo     (ch_mlo[c]),
      .mir_hi     (ch_mhi[c])
    );

    dsr_rx_ring #(.DATA_W(DW), .DEPTH(RING_DEPTH)) u_ring (
      .clk       (clk),
      .rst       (rst),
      .push      (push),
      .push_data (push_d),
      .pop       (dat_rd && (bus_ch == 1'(c))),
      .pop_data  (ch_pop[c]),
      .not_empty (avail[c]),
      .overrun   (rx_overrun[c])
    );
  end

  // all interrupt controls are taken from channel A
  dsr_irq_ctl u_irq (
    .clk        (clk),
    .rst        (rst),
    .master_en  (ch_master[0]),
    .rx_mode_en (ch_rxmode[0]),
    .ext_en     (ch_ext[0]),
    .tx_ie      (tx_ie),
    .avail      (avail),
    .tx_fire    (tx_fire),
    .clr        (clr),
    .pend       (pend),
    .irq        (irq)
  );

  assign clr = dat_rd ||
               (ch_cmd_rd[0] && (ch_sel[0] == IDX_W'(RR_PEND)));

  logic [DW-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    case (ch_sel[bus_ch])
      IDX_W'(RR_STATUS): begin
        rd_val[B_AVAIL]  = avail[bus_ch];
        rd_val[B_TXEMPT] = 1'b1;
      end
      IDX_W'(RR_ERR):    rd_val = '0;
      IDX_W'(RR_PEND):   rd_val = (bus_ch == 1'b0) ? DW'(pend) : '0;
      IDX_W'(RR_MIR_LO): rd_val = ch_mlo[bus_ch];
      IDX_W'(RR_MIR_HI): rd_val = ch_mhi[bus_ch];
      default:           rd_val = '0;
    endcase
  end

  logic [DW-1:0] rd_reg_q;
  logic          rd_ring_q, rd_ring_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg_q   <= '0;
      rd_ring_q  <= 1'b0;
      rd_ring_ch <= 1'b0;
      tx_valid   <= 1'b0;
      tx_chan    <= 1'b0;
      tx_data    <= '0;
    end else begin
      if (bus_rd) begin
        rd_reg_q   <= cmd_acc ? rd_val : '0;
        rd_ring_q  <= dat_acc;
        rd_ring_ch <= bus_ch;
      end
      tx_valid <= dat_wr;
      if (dat_wr) begin
        tx_data <= bus_wdata;
        tx_chan <= bus_ch;
      end
    end
  end

  assign bus_rdata = rd_ring_q ? ch_pop[rd_ring_ch] : rd_reg_q;

  AST_TX_ECHO: assert property (@(posedge clk) disable iff (rst)
    bus_wr && dat_acc |=> tx_valid && tx_data == $past(bus_wdata)); // R6

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && dat_acc) |=> !tx_valid); // R6
endmodule

// File: tb/dsr_top_tb.sv
module dsr_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_valid, tx_chan;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_chan = 1'b0;
  logic [7:0] rx_data = '0;
  logic [1:0] rx_overrun;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       cap_txv, cap_txc;
  logic [7:0] cap_txd;
  logic [7:0] rv;

  always #5 clk = ~clk;

  dsr_top u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_chan(tx_chan), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_data(rx_data),
    .rx_overrun(rx_overrun), .irq(irq)
  );

  localparam logic [3:0] A_CMD = 4'd1, A_DAT = 4'd5, B_CMD = 4'd9, B_DAT = 4'd13;

  // {op[25], req[24:21], addr[20:17], data[16:9], pad, expect[7:0]}; op 0 write, 1 read
  localparam int NV = 17;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 4'd2, A_CMD, 8'h0C, 1'b0, 8'h00},  // R2 select 12
    {1'b0, 4'd2, A_CMD, 8'h5A, 1'b0, 8'h00},  // R2 store
    {1'b0, 4'd2, B_CMD, 8'h0C, 1'b0, 8'h00},
    {1'b0, 4'd2, B_CMD, 8'hA5, 1'b0, 8'h00},
    {1'b0, 4'd2, A_CMD, 8'h0D, 1'b0, 8'h00},
    {1'b0, 4'd2, A_CMD, 8'h3C, 1'b0, 8'h00},
    {1'b0, 4'd4, A_CMD, 8'h0C, 1'b0, 8'h00},
    {1'b1, 4'd4, A_CMD, 8'h00, 1'b0, 8'h5A},  // R4 mirror A
    {1'b1, 4'd3, A_CMD, 8'h00, 1'b0, 8'h04},  // R3 index back at 0
    {1'b0, 4'd4, B_CMD, 8'h0C, 1'b0, 8'h00},
    {1'b1, 4'd4, B_CMD, 8'h00, 1'b0, 8'hA5},  // R4 mirror B
    {1'b0, 4'd2, B_CMD, 8'h1D, 1'b0, 8'h00},  // R2 low 4 bits only
    {1'b1, 4'd2, B_CMD, 8'h00, 1'b0, 8'h00},
    {1'b0, 4'd4, A_CMD, 8'h0D, 1'b0, 8'h00},
    {1'b1, 4'd4, A_CMD, 8'h00, 1'b0, 8'h3C},
    {1'b0, 4'd5, A_CMD, 8'h01, 1'b0, 8'h00},
    {1'b1, 4'd5, A_CMD, 8'h00, 1'b0, 8'h00}   // R5 error register
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    cap_txv = tx_valid; cap_txc = tx_chan; cap_txd = tx_data;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_reg(input logic ch, input logic [3:0] idx, input logic [7:0] v);
    bus_write(ch ? B_CMD : A_CMD, {4'h0, idx});
    bus_write(ch ? B_CMD : A_CMD, v);
  endtask

  task automatic get_reg(input logic ch, input logic [3:0] idx, output logic [7:0] d);
    bus_write(ch ? B_CMD : A_CMD, {4'h0, idx});
    bus_read(ch ? B_CMD : A_CMD, d);
  endtask

  task automatic rx_push(input logic ch, input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_chan = ch; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rx_overrun", rx_overrun, 0);
    chk("R1 bus_rdata", bus_rdata, 0);
    bus_read(A_CMD, rv); chk("R1 status A", rv, 8'h04);
    bus_read(B_CMD, rv); chk("R1 status B", rv, 8'h04);

    // R2 R3 R4 R5 register vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25] == 1'b0) begin
        bus_write(VEC[i][20:17], VEC[i][16:9]);
      end else begin
        bus_read(VEC[i][20:17], rv);
        chk($sformatf("R%0d vector %0d", VEC[i][24:21], i), rv, VEC[i][7:0]);
      end
    end

    // R6 transmit strobe
    bus_write(A_DAT, 8'h41);
    chk("R6 tx_valid", cap_txv, 1);
    chk("R6 tx_data", cap_txd, 8'h41);
    chk("R6 tx_chan A", cap_txc, 0);
    idle(1);
    chk("R6 single pulse", tx_valid, 0);
    bus_write(B_DAT, 8'hC3);
    chk("R6 tx_chan B", cap_txc, 1);
    chk("R6 tx_data B", cap_txd, 8'hC3);

    // R7 order and empty read, R5 availability
    rx_push(1'b1, 8'h11);
    rx_push(1'b1, 8'h22);
    get_reg(1'b1, 4'd0, rv); chk("R5 status B avail", rv, 8'h05);
    get_reg(1'b0, 4'd0, rv); chk("R5 status A empty", rv, 8'h04);
    bus_read(B_DAT, rv); chk("R7 first byte", rv, 8'h11);
    bus_read(B_DAT, rv); chk("R7 second byte", rv, 8'h22);
    get_reg(1'b1, 4'd0, rv); chk("R5 status B drained", rv, 8'h04);
    bus_read(A_DAT, rv); chk("R7 empty read", rv, 8'h00);
    rx_push(1'b0, 8'h31);
    bus_read(A_DAT, rv); chk("R7 after empty read", rv, 8'h31);

    // R8 loopback
    set_reg(1'b0, 4'd14, 8'h10);
    bus_write(A_DAT, 8'h77);
    chk("R8 tx still sent", cap_txd, 8'h77);
    get_reg(1'b1, 4'd0, rv); chk("R8 other channel untouched", rv, 8'h04);
    bus_read(A_DAT, rv); chk("R8 looped byte", rv, 8'h77);
    set_reg(1'b0, 4'd14, 8'h00);
    bus_write(A_DAT, 8'h78);
    get_reg(1'b0, 4'd0, rv); chk("R8 loop off", rv, 8'h04);

    // R9 R11 R12 transmit pending
    set_reg(1'b0, 4'd9, 8'h08);
    set_reg(1'b1, 4'd1, 8'h02);
    bus_write(B_DAT, 8'h55);
    idle(2);
    chk("R11 irq on tx B", irq, 1);
    get_reg(1'b0, 4'd3, rv); chk("R9 tx pending B", rv, 8'h02);
    idle(2);
    chk("R12 irq cleared", irq, 0);
    bus_write(A_DAT, 8'h66);
    idle(2);
    chk("R9 tx A disabled irq", irq, 0);
    get_reg(1'b0, 4'd3, rv); chk("R9 tx A disabled pending", rv, 8'h00);

    // R10 receive pending
    set_reg(1'b0, 4'd1, 8'h10);
    rx_push(1'b0, 8'h99);
    idle(2);
    chk("R11 irq on rx A", irq, 1);
    get_reg(1'b0, 4'd3, rv); chk("R10 rx pending A", rv, 8'h20);
    bus_read(A_DAT, rv); chk("R7 rx A byte", rv, 8'h99);
    idle(2);
    chk("R12 irq after data read", irq, 0);
    get_reg(1'b0, 4'd3, rv); chk("R12 pending empty", rv, 8'h00);
    rx_push(1'b1, 8'h12);
    idle(2);
    get_reg(1'b0, 4'd3, rv); chk("R10 rx pending B", rv, 8'h04);
    bus_read(B_DAT, rv); chk("R7 rx B byte", rv, 8'h12);

    // R10 external pending
    set_reg(1'b0, 4'd1, 8'h80);
    rx_push(1'b1, 8'hAB);
    idle(2);
    chk("R11 irq on ext B", irq, 1);
    get_reg(1'b0, 4'd3, rv); chk("R10 ext pending B", rv, 8'h01);
    bus_read(B_DAT, rv); chk("R7 ext B byte", rv, 8'hAB);
    idle(2);
    chk("R12 irq ext cleared", irq, 0);

    // R11 master enable off
    set_reg(1'b0, 4'd9, 8'h00);
    set_reg(1'b0, 4'd1, 8'h10);
    rx_push(1'b0, 8'h3E);
    idle(3);
    chk("R11 irq masked", irq, 0);
    get_reg(1'b0, 4'd3, rv); chk("R10 no pending when masked", rv, 8'h00);
    bus_read(A_DAT, rv); chk("R7 masked byte", rv, 8'h3E);

    // R13 overrun boundary on channel A
    @(negedge clk);
    rx_valid = 1'b1; rx_chan = 1'b0;
    for (int i = 0; i < 1023; i++) begin
      rx_data = 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    chk("R13 no overrun at 1023", rx_overrun, 2'b00);
    get_reg(1'b0, 4'd0, rv); chk("R13 full ring avail", rv, 8'h05);
    rx_push(1'b0, 8'hEE);
    chk("R13 overrun A", rx_overrun, 2'b01);
    get_reg(1'b0, 4'd0, rv); chk("R13 ring reads empty", rv, 8'h04);
    idle(4);
    chk("R13 overrun sticky", rx_overrun, 2'b01);

    finish_run();
  end
endmodule